// File: doc/BRIEF.md
# Page Access Rights Checker

This block sits behind a translation lookaside lookup and turns its result into what the load/store and fetch paths need: a physical address, a three-bit read/write/execute permission mask, and a fault indication. It is purely combinational. The caller supplies the requested access kind, the current privilege level, the global translation and protection-id enables, four protection-id registers, a miss flag, and the fields of the matching entry. The fields are start address, physical base, two privilege bounds, a type code, an access id, and the dirty, break and trap bits.

The check runs as a fixed chain of steps. Translation bypass and miss handling come first. Then the privilege ranges are applied, and the type code picks which of them count. Protection-id matching can then strip write and may end the chain. An access kind of "none" stops the chain at that point. Otherwise the requested right is tested, and last come the dirty, break and trap checks. Among those three, a later fault takes precedence over an earlier one. The physical address is driven even while a fault is reported, so the exception logic can record it.

Top module: `page_rights_check`

## Requirements
- R1: With `xlate_en` low, `pa_out` equals `va`, `perm_mask` is 3'b111 (bit 0 read, bit 1 write, bit 2 execute), and `fault_valid` is low with `fault_code` 0 (none).
- R2: With `xlate_en` high and `ent_miss` high, `pa_out` is 0 and `perm_mask` is 0. `fault_code` is 1 (instruction miss) for an execute access (`acc_type` 3). It is 2 (data miss) for every other access kind (0 none, 1 read, 2 write).
- R3: On a hit, `pa_out` is `ent_pa_base + (va - ent_va_start)`. This value is driven whether or not a fault is reported.
- R4: Privilege sets the candidate rights. Read needs `cur_priv <= ent_pl1`. Write needs `cur_priv <= ent_pl2`. Execute needs `ent_pl2 <= cur_priv <= ent_pl1`. Lower numbers are more privileged.
- R5: `ent_type` selects which candidate rights apply: 0 read, 1 read+write, 2 read+execute, 3 all three, 4 to 7 execute only.
- R6: A protection-id match occurs when `pid_chk_en` is high, `ent_aid` is nonzero, and any of the four registers equals `{ent_aid,1'b1}`. A match clears write from the mask. A write access that matches reports fault 3 (protection id), and no later check applies.
- R7: Access kind 0 (none) on a hit returns the mask built so far with no fault. The dirty, break and trap bits have no effect in that case.
- R8: If the requested right is absent from the mask, the fault is 4 (instruction protection) for execute and 5 (data access rights) for read or write. The mask is returned unchanged.
- R9: When the requested right is present and the dirty bit is clear, write is removed from the mask whatever the access kind. A write access then reports fault 6 (dirty).
- R10: When the break bit is set, write is removed from the mask. A write access reports fault 7 (break), and this overrides a dirty fault.
- R11: When the trap bit is set, only execute is left in the mask. A read or write access reports fault 8 (page reference), and this overrides both dirty and break faults.
- R12: `fault_valid` is high exactly when `fault_code` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_type | input | 2 | Access kind: 0 none, 1 read, 2 write, 3 execute |
| cur_priv | input | PRIV_W | Current privilege level |
| xlate_en | input | 1 | Translation enable; low bypasses the check |
| pid_chk_en | input | 1 | Enables protection-id matching |
| pid_regs | input | NUM_PID*PID_W | Protection-id registers, register k at bits [k*PID_W +: PID_W] |
| va | input | VA_W | Virtual address of the access |
| ent_miss | input | 1 | No matching valid entry was found |
| ent_va_start | input | VA_W | Entry start virtual address |
| ent_pa_base | input | PA_W | Entry physical base |
| ent_pl1 | input | PRIV_W | Entry read/execute privilege bound |
| ent_pl2 | input | PRIV_W | Entry write/execute privilege bound |
| ent_type | input | 3 | Entry rights type code |
| ent_aid | input | AID_W | Entry access id; 0 means public |
| ent_dirty | input | 1 | Entry dirty bit |
| ent_break | input | 1 | Entry break bit |
| ent_trap | input | 1 | Entry reference-trap bit |
| pa_out | output | PA_W | Physical address |
| perm_mask | output | 3 | Granted rights: bit 0 read, bit 1 write, bit 2 execute |
| fault_valid | output | 1 | A fault is reported |
| fault_code | output | 4 | Fault code, 0 when none |

## Verification
Privilege is swept across positions below, inside and above the two bounds, and each of the eight type codes is covered. Together these separate range errors from type-selection errors. Protection-id cases vary the enable, a zero id, a register value with the low bit clear, and the read or write kind. This shows that only a full odd-value match strips write, and only a write faults. Dirty, break and trap bits are applied singly and together under read, write, execute and none accesses. This exposes the override order and the fact that mask trimming does not depend on the access kind.

// File: rtl/page_rights_pkg.sv
package page_rights_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_EXEC  = 2'd3
    } acc_e;

    typedef enum logic [3:0] {
        FLT_NONE   = 4'd0,
        FLT_IMISS  = 4'd1,
        FLT_DMISS  = 4'd2,
        FLT_PID    = 4'd3,
        FLT_IPROT  = 4'd4,
        FLT_DRIGHT = 4'd5,
        FLT_DIRTY  = 4'd6,
        FLT_BREAK  = 4'd7,
        FLT_PREF   = 4'd8
    } fault_e;

    localparam int unsigned BIT_R = 0;
    localparam int unsigned BIT_W = 1;
    localparam int unsigned BIT_X = 2;

    function automatic logic [2:0] need_mask(acc_e a);
        unique case (a)
            ACC_READ:  need_mask = 3'b001;
            ACC_WRITE: need_mask = 3'b010;
            ACC_EXEC:  need_mask = 3'b100;
            default:   need_mask = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/page_rights_eval.sv
module page_rights_eval #(
    parameter int unsigned PRIV_W = 2
) (
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic [PRIV_W-1:0] pl1,
    input  logic [PRIV_W-1:0] pl2,
    input  logic [2:0]        type_code,
    output logic [2:0]        mask
);
    import page_rights_pkg::*;

    logic can_r;
    logic can_w;
    logic can_x;

    always_comb begin
        can_r = (cur_priv <= pl1);
        can_w = (cur_priv <= pl2);
        can_x = (pl2 <= cur_priv) && (cur_priv <= pl1);
    end

    always_comb begin
        mask = '0;
        unique case (type_code)
            3'd0: mask[BIT_R] = can_r;
            3'd1: begin
                mask[BIT_R] = can_r;
                mask[BIT_W] = can_w;
            end
            3'd2: begin
                mask[BIT_R] = can_r;
                mask[BIT_X] = can_x;
            end
            3'd3: begin
                mask[BIT_R] = can_r;
                mask[BIT_W] = can_w;
                mask[BIT_X] = can_x;
            end
            default: mask[BIT_X] = can_x;
        endcase
    end
endmodule

// File: rtl/page_rights_pid.sv
module page_rights_pid #(
    parameter int unsigned NUM_PID = 4,
    parameter int unsigned PID_W   = 32,
    parameter int unsigned AID_W   = 18
) (
    input  logic                     chk_en,
    input  logic [NUM_PID*PID_W-1:0] pid_regs,
    input  logic [AID_W-1:0]         aid,
    output logic                     hit
);
    localparam int unsigned KEY_W = AID_W + 1;

    logic [PID_W-1:0]   key;
    logic [NUM_PID-1:0] eq;

    always_comb key = PID_W'({aid, 1'b1});

    for (genvar k = 0; k < NUM_PID; k++) begin : g_cmp
        always_comb eq[k] = (pid_regs[k*PID_W +: PID_W] == key);
    end

    always_comb hit = chk_en && (aid != '0) && (|eq);

    initial begin
        if (KEY_W > PID_W) $error("page_rights_pid: PID_W too narrow");
    end
endmodule

// File: rtl/page_rights_chain.sv
module page_rights_chain (
    input  page_rights_pkg::acc_e   acc,
    input  logic [2:0]              base_mask,
    input  logic                    pid_hit,
    input  logic                    dirty,
    input  logic                    brk,
    input  logic                    trap,
    output logic [2:0]              mask,
    output page_rights_pkg::fault_e fault
);
    import page_rights_pkg::*;

    logic [2:0] pid_mask;
    logic [2:0] dbt_mask;
    fault_e     dbt_fault;

    always_comb begin
        pid_mask = base_mask;
        if (pid_hit) pid_mask[BIT_W] = 1'b0;
    end

    // dirty, break, trap in rising precedence
    always_comb begin
        dbt_mask  = pid_mask;
        dbt_fault = FLT_NONE;
        if (!dirty) begin
            if (acc == ACC_WRITE) dbt_fault = FLT_DIRTY;
            dbt_mask[BIT_W] = 1'b0;
        end
        if (brk) begin
            if (acc == ACC_WRITE) dbt_fault = FLT_BREAK;
            dbt_mask[BIT_W] = 1'b0;
        end
        if (trap) begin
            if (acc != ACC_EXEC) dbt_fault = FLT_PREF;
            dbt_mask = dbt_mask & 3'b100;
        end
    end

    always_comb begin
        mask  = pid_mask;
        fault = FLT_NONE;
        if (pid_hit && acc == ACC_WRITE) begin
            fault = FLT_PID;
        end else if (acc == ACC_NONE) begin
            fault = FLT_NONE;
        end else if ((pid_mask & need_mask(acc)) == 3'b000) begin
            fault = (acc == ACC_EXEC) ? FLT_IPROT : FLT_DRIGHT;
        end else begin
            mask  = dbt_mask;
            fault = dbt_fault;
        end
    end
endmodule

// File: rtl/page_rights_check.sv
module page_rights_check #(
    parameter int unsigned VA_W    = 32,
    parameter int unsigned PA_W    = 32,
    parameter int unsigned PRIV_W  = 2,
    parameter int unsigned AID_W   = 18,
    parameter int unsigned PID_W   = 32,
    parameter int unsigned NUM_PID = 4
) (
    input  logic [1:0]               acc_type,
    input  logic [PRIV_W-1:0]        cur_priv,
    input  logic                     xlate_en,
    input  logic                     pid_chk_en,
    input  logic [NUM_PID*PID_W-1:0] pid_regs,
    input  logic [VA_W-1:0]          va,
    input  logic                     ent_miss,
    input  logic [VA_W-1:0]          ent_va_start,
    input  logic [PA_W-1:0]          ent_pa_base,
    input  logic [PRIV_W-1:0]        ent_pl1,
    input  logic [PRIV_W-1:0]        ent_pl2,
    input  logic [2:0]               ent_type,
    input  logic [AID_W-1:0]         ent_aid,
    input  logic                     ent_dirty,
    input  logic                     ent_break,
    input  logic                     ent_trap,
    output logic [PA_W-1:0]          pa_out,
    output logic [2:0]               perm_mask,
    output logic                     fault_valid,
    output logic [3:0]               fault_code
);
    import page_rights_pkg::*;

    acc_e       acc;
    logic [2:0] rng_mask;
    logic       pid_hit;
    logic [2:0] hit_mask;
    fault_e     hit_fault;
    logic [VA_W-1:0] offset;
    fault_e     fault_sel;

    always_comb acc = acc_e'(acc_type);

    page_rights_eval #(.PRIV_W(PRIV_W)) eval_i (
        .cur_priv  (cur_priv),
        .pl1       (ent_pl1),
        .pl2       (ent_pl2),
        .type_code (ent_type),
        .mask      (rng_mask)
    );

    page_rights_pid #(.NUM_PID(NUM_PID), .PID_W(PID_W), .AID_W(AID_W)) pid_i (
        .chk_en   (pid_chk_en),
        .pid_regs (pid_regs),
        .aid      (ent_aid),
        .hit      (pid_hit)
    );

    page_rights_chain chain_i (
        .acc       (acc),
        .base_mask (rng_mask),
        .pid_hit   (pid_hit),
        .dirty     (ent_dirty),
        .brk       (ent_break),
        .trap      (ent_trap),
        .mask      (hit_mask),
        .fault     (hit_fault)
    );

    always_comb offset = va - ent_va_start;

    always_comb begin
        if (!xlate_en) begin
            pa_out    = PA_W'(va);
            perm_mask = 3'b111;
            fault_sel = FLT_NONE;
        end else if (ent_miss) begin
            pa_out    = '0;
            perm_mask = 3'b000;
            fault_sel = (acc == ACC_EXEC) ? FLT_IMISS : FLT_DMISS;
        end else begin
            pa_out    = ent_pa_base + PA_W'(offset);
            perm_mask = hit_mask;
            fault_sel = hit_fault;
        end
    end

    always_comb begin
        fault_code  = fault_sel;
        fault_valid = (fault_sel != FLT_NONE);
    end
endmodule

// File: rtl/page_rights_check_chk.sv
module page_rights_check_chk #(
    parameter int unsigned VA_W = 32,
    parameter int unsigned PA_W = 32
) (
    input logic [1:0]      acc_type,
    input logic            xlate_en,
    input logic            ent_miss,
    input logic [VA_W-1:0] va,
    input logic [PA_W-1:0] pa_out,
    input logic [2:0]      perm_mask,
    input logic            fault_valid,
    input logic [3:0]      fault_code
);
    always_comb begin
        // R1
        if (!xlate_en) begin
            bypass_open_chk: assert (perm_mask == 3'b111 && !fault_valid && pa_out == PA_W'(va))
                else $error("bypass output wrong");
        end
        // R2
        if (xlate_en && ent_miss) begin
            miss_code_chk: assert (fault_code == ((acc_type == 2'd3) ? 4'd1 : 4'd2) && perm_mask == 3'b000)
                else $error("miss code wrong");
        end
        // R7
        if (xlate_en && !ent_miss && acc_type == 2'd0) begin
            none_quiet_chk: assert (!fault_valid)
                else $error("none access faulted");
        end
        // R6
        if (fault_code == 4'd3) begin
            pid_write_chk: assert (acc_type == 2'd2 && !perm_mask[1])
                else $error("pid fault inconsistent");
        end
        // R9
        if (fault_code == 4'd6 || fault_code == 4'd7) begin
            db_write_chk: assert (acc_type == 2'd2 && !perm_mask[1])
                else $error("dirty/break fault inconsistent");
        end
        // R11
        if (fault_code == 4'd8) begin
            pref_mask_chk: assert (perm_mask[1:0] == 2'b00 && acc_type != 2'd3)
                else $error("page reference fault inconsistent");
        end
        // R12
        fault_flag_chk: assert (fault_valid == (fault_code != 4'd0))
            else $error("fault_valid mismatch");
    end
endmodule

bind page_rights_check page_rights_check_chk #(.VA_W(VA_W), .PA_W(PA_W)) chk_i (
    .acc_type    (acc_type),
    .xlate_en    (xlate_en),
    .ent_miss    (ent_miss),
    .va          (va),
    .pa_out      (pa_out),
    .perm_mask   (perm_mask),
    .fault_valid (fault_valid),
    .fault_code  (fault_code)
);

// File: tb/page_rights_check_tb_top.sv
`timescale 1ns/1ps
module page_rights_check_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [1:0]   acc_type;
    logic [1:0]   cur_priv;
    logic         xlate_en, pid_chk_en, ent_miss;
    logic [127:0] pid_regs;
    logic [31:0]  va, ent_va_start, ent_pa_base;
    logic [1:0]   ent_pl1, ent_pl2;
    logic [2:0]   ent_type;
    logic [17:0]  ent_aid;
    logic         ent_dirty, ent_break, ent_trap;
    logic [31:0]  pa_out;
    logic [2:0]   perm_mask;
    logic         fault_valid;
    logic [3:0]   fault_code;

    int checks = 0;
    int failures = 0;

    page_rights_check dut_i (
        .acc_type(acc_type), .cur_priv(cur_priv), .xlate_en(xlate_en),
        .pid_chk_en(pid_chk_en), .pid_regs(pid_regs), .va(va),
        .ent_miss(ent_miss), .ent_va_start(ent_va_start), .ent_pa_base(ent_pa_base),
        .ent_pl1(ent_pl1), .ent_pl2(ent_pl2), .ent_type(ent_type), .ent_aid(ent_aid),
        .ent_dirty(ent_dirty), .ent_break(ent_break), .ent_trap(ent_trap),
        .pa_out(pa_out), .perm_mask(perm_mask), .fault_valid(fault_valid),
        .fault_code(fault_code)
    );

    task automatic expect_out(string req, logic [31:0] e_pa, logic [2:0] e_mask, logic [3:0] e_code);
        #2;
        checks++;
        if (pa_out !== e_pa || perm_mask !== e_mask || fault_code !== e_code
            || fault_valid !== (e_code != 4'd0)) begin
            failures++;
            $display("FAIL %s: pa=%h mask=%b code=%0d valid=%b expected pa=%h mask=%b code=%0d",
                     req, pa_out, perm_mask, fault_code, fault_valid, e_pa, e_mask, e_code);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    // hit entry with full rights range: pl1=3 pl2=0 priv 0
    task automatic base_hit(logic [2:0] t);
        xlate_en = 1; ent_miss = 0; pid_chk_en = 0; pid_regs = '0;
        ent_va_start = 32'h0001_0000; ent_pa_base = 32'h8000_0000;
        va = 32'h0001_0ABC; cur_priv = 0; ent_pl1 = 3; ent_pl2 = 0;
        ent_type = t; ent_aid = 0; ent_dirty = 1; ent_break = 0; ent_trap = 0;
    endtask

    localparam logic [31:0] HPA = 32'h8000_0ABC;

    task automatic t_bypass();
        xlate_en = 0; ent_miss = 1; acc_type = 2; va = 32'h1234_5678;
        expect_out("R1 bypass write", 32'h1234_5678, 3'b111, 0);
        acc_type = 3; ent_trap = 1;
        expect_out("R1 bypass exec", 32'h1234_5678, 3'b111, 0);
    endtask

    task automatic t_miss();
        base_hit(3); ent_miss = 1;
        acc_type = 3; expect_out("R2 miss exec", 0, 3'b000, 1);
        acc_type = 1; expect_out("R2 miss read", 0, 3'b000, 2);
        acc_type = 2; expect_out("R2 miss write", 0, 3'b000, 2);
        acc_type = 0; expect_out("R2 miss none", 0, 3'b000, 2);
    endtask

    task automatic t_addr_types();
        base_hit(1); acc_type = 1;
        expect_out("R3 R5 type1", HPA, 3'b011, 0);
        base_hit(0); acc_type = 0; expect_out("R5 type0", HPA, 3'b001, 0);
        base_hit(2); acc_type = 0; expect_out("R5 type2", HPA, 3'b101, 0);
        base_hit(3); acc_type = 0; expect_out("R5 type3", HPA, 3'b111, 0);
        for (int t = 4; t < 8; t++) begin
            base_hit(3'(t)); acc_type = 0;
            expect_out("R5 type4-7", HPA, 3'b100, 0);
        end
        base_hit(1); va = 32'h0001_3000; ent_pa_base = 32'h0000_2000; acc_type = 3;
        expect_out("R3 R8 pa with fault", 32'h0000_5000, 3'b011, 4);
    endtask

    task automatic t_priv();
        base_hit(3); ent_pl1 = 1; ent_pl2 = 0; cur_priv = 2; acc_type = 1;
        expect_out("R4 R8 above pl1 read", HPA, 3'b000, 5);
        cur_priv = 1; acc_type = 3;
        expect_out("R4 mid exec", HPA, 3'b101, 0);
        acc_type = 2;
        expect_out("R4 R8 write denied", HPA, 3'b101, 5);
        ent_pl2 = 2; cur_priv = 1; acc_type = 3;
        expect_out("R4 R8 exec below pl2", HPA, 3'b011, 4);
    endtask

    task automatic t_pid();
        base_hit(1); pid_chk_en = 1; ent_aid = 18'd5;
        pid_regs = {32'h0, 32'h0000_000B, 32'h0, 32'h0};
        acc_type = 2; expect_out("R6 pid write", HPA, 3'b001, 3);
        acc_type = 1; expect_out("R6 pid read", HPA, 3'b001, 0);
        ent_dirty = 0; acc_type = 2;
        expect_out("R6 pid before dirty", HPA, 3'b001, 3);
        ent_dirty = 1; pid_regs = {32'h0000_000A, 96'h0};
        expect_out("R6 even value no match", HPA, 3'b011, 0);
        ent_aid = 0; pid_regs = {96'h0, 32'h0000_0001};
        expect_out("R6 public id", HPA, 3'b011, 0);
        ent_aid = 18'd5; pid_regs = {32'h0000_000B, 96'h0}; pid_chk_en = 0;
        expect_out("R6 check disabled", HPA, 3'b011, 0);
    endtask

    task automatic t_dbt();
        base_hit(3); acc_type = 2; ent_dirty = 0;
        expect_out("R9 dirty write", HPA, 3'b101, 6);
        acc_type = 1;
        expect_out("R9 dirty read trims", HPA, 3'b101, 0);
        acc_type = 2; ent_break = 1;
        expect_out("R10 break over dirty", HPA, 3'b101, 7);
        ent_dirty = 1; acc_type = 1;
        expect_out("R10 break read", HPA, 3'b101, 0);
        acc_type = 2; ent_dirty = 0; ent_trap = 1;
        expect_out("R11 trap over all", HPA, 3'b100, 8);
        acc_type = 1; ent_break = 0; ent_dirty = 1;
        expect_out("R11 trap read", HPA, 3'b100, 8);
        acc_type = 3;
        expect_out("R11 trap exec", HPA, 3'b100, 0);
        acc_type = 0; ent_dirty = 0; ent_break = 1;
        expect_out("R7 none skips dbt", HPA, 3'b111, 0);
    endtask

    initial begin
        acc_type = 0; cur_priv = 0; xlate_en = 0; pid_chk_en = 0; pid_regs = '0;
        va = 32'h0000_0040; ent_miss = 0; ent_va_start = 0; ent_pa_base = 0;
        ent_pl1 = 0; ent_pl2 = 0; ent_type = 0; ent_aid = 0;
        ent_dirty = 0; ent_break = 0; ent_trap = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 R12 idle state", 32'h0000_0040, 3'b111, 0);
        t_bypass();
        t_miss();
        t_addr_types();
        t_priv();
        t_pid();
        t_dbt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule